// File: doc/BRIEF.md
# Consecutive Mute Frame Detector

This block sits on the receive side of a time-slotted audio interface. Each time a frame ends, the upstream slot logic presents one frame report. The report carries a single bit that says whether the frame was silent, which means every active slot held all-zero data. The detector counts how many silent frames arrive in a row. When that run length equals a programmable threshold, it sets a sticky detection flag. It also drives an interrupt line, which is the flag gated by an enable.

Frame reports use a valid/ready handshake. The detector never applies back-pressure: `frm_ready` is high in every cycle, including during reset, so a report is taken in any cycle where `frm_valid` is high. Reports are counted only while `rx_mode` is high. While it is low, reports are accepted and then discarded, and the run count is left as it was.

A non-silent frame sets the run back to zero. After a match, the counter stops firing and stays that way until a non-silent frame re-arms it. Software clears the flag with a one-cycle pulse on `det_clr`.

Top module: `mute_run_detector`

## Requirements
- R1: After reset, `det_flag` and `det_irq` are 0.
- R2: `frm_ready` is 1 in every cycle, so a report is accepted in every cycle where `frm_valid` is 1.
- R3: With `cfg_threshold` = N (N > 0), the edge that accepts the Nth consecutive silent report (`frm_silent` = 1) sets `det_flag`. It is visible in the cycle after that edge.
- R4: An accepted report with `frm_silent` = 0 resets the run to zero. N-1 silent reports, then a loud one, then N-1 more silent reports do not set the flag.
- R5: Once a match has occurred, further silent reports do not fire again until a loud report has been accepted.
- R6: `cfg_threshold` = 0 never sets `det_flag`, whatever the run length.
- R7: Reports accepted while `rx_mode` = 0 are ignored. They neither advance nor reset the run.
- R8: `det_flag` stays set until a one-cycle pulse on `det_clr`. It reads 0 in the cycle after the pulse.
- R9: `det_irq` is 1 exactly when `det_flag` = 1 and `irq_en` = 1.
- R10: If a match and `det_clr` fall in the same cycle, the match wins and `det_flag` is 1 afterwards.
- R11: `frm_silent` has no effect in cycles where `frm_valid` = 0.
- R12: The largest threshold, 63, matches on the 63rd silent report, and a longer run does not wrap round to fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_mode | input | 1 | High when the audio block is receiving |
| cfg_threshold | input | 6 | Run length that triggers detection; 0 disables |
| irq_en | input | 1 | Interrupt enable |
| det_clr | input | 1 | One-cycle pulse that clears the flag |
| frm_valid | input | 1 | Frame report valid |
| frm_silent | input | 1 | Reported frame was silent |
| frm_ready | output | 1 | Always 1; the detector never stalls |
| det_flag | output | 1 | Sticky detection flag |
| det_irq | output | 1 | Flag gated by `irq_en` |

## Verification
The hardest state to reach is the saturated one at the largest threshold. It needs a run of 63 silent reports with nothing breaking it, followed by more silent reports, to show that the count neither re-matches nor wraps round. The bench drives such an unbroken run and clears the flag after the match, so that any second firing would show up at the port. It also places a loud report during a period when `rx_mode` is low, which separates the case where a report is ignored from the case where it resets the run.

// File: rtl/mute_det_pkg.sv
package mute_det_pkg;
  // Width of the programmable run-length threshold
  localparam int unsigned MD_THR_W = 6;
  typedef logic [MD_THR_W-1:0] md_thr_t;
endpackage

// File: rtl/mute_run_counter.sv
module mute_run_counter #(
  parameter int unsigned THR_W = mute_det_pkg::MD_THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             silent_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             hit_o
);
  localparam logic [THR_W-1:0] RUN_MAX = '1;

  logic [THR_W-1:0] run_q;
  logic [THR_W:0]   run_inc;
  logic             armed_q;

  always_comb begin
    run_inc = {1'b0, run_q} + 1'b1;
    hit_o   = step_i && silent_i && armed_q && (thr_i != '0) &&
              (run_inc == {1'b0, thr_i});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b1;
    end else if (step_i) begin
      if (!silent_i) begin
        run_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        if (run_q != RUN_MAX) run_q <= run_inc[THR_W-1:0];
        if (hit_o) armed_q <= 1'b0;
      end
    end
  end

  // R6
  thr_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_i == '0) |-> !hit_o);
endmodule

// File: rtl/mute_det_flag.sv
module mute_det_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/mute_run_detector.sv
module mute_run_detector #(
  parameter int unsigned THR_W = mute_det_pkg::MD_THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_mode,
  input  logic [THR_W-1:0] cfg_threshold,
  input  logic             irq_en,
  input  logic             det_clr,
  input  logic             frm_valid,
  input  logic             frm_silent,
  output logic             frm_ready,
  output logic             det_flag,
  output logic             det_irq
);
  logic step;
  logic hit;

  assign frm_ready = 1'b1;
  assign step      = frm_valid && frm_ready && rx_mode;

  mute_run_counter #(.THR_W(THR_W)) counter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step),
    .silent_i (frm_silent),
    .thr_i    (cfg_threshold),
    .hit_o    (hit)
  );

  mute_det_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hit),
    .clr_i  (det_clr),
    .en_i   (irq_en),
    .flag_o (det_flag),
    .irq_o  (det_irq)
  );

  // R3
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> det_flag);

  // R5
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  // R7
  idle_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode |-> !hit);
endmodule

// File: tb/mute_run_detector_tb_top.sv
`timescale 1ns/1ps
module mute_run_detector_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_mode = 1'b1;
  logic [5:0] cfg_threshold = '0;
  logic       irq_en = 1'b0;
  logic       det_clr = 1'b0;
  logic       frm_valid = 1'b0;
  logic       frm_silent = 1'b0;
  logic       frm_ready, det_flag, det_irq;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mute_run_detector dut_i (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .cfg_threshold(cfg_threshold),
    .irq_en(irq_en), .det_clr(det_clr), .frm_valid(frm_valid),
    .frm_silent(frm_silent), .frm_ready(frm_ready), .det_flag(det_flag),
    .det_irq(det_irq)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send(input logic silent, input logic clr = 1'b0);
    frm_valid  = 1'b1;
    frm_silent = silent;
    det_clr    = clr;
    @(negedge clk);
    frm_valid  = 1'b0;
    det_clr    = 1'b0;
  endtask

  task automatic pulse_clr();
    det_clr = 1'b1;
    @(negedge clk);
    det_clr = 1'b0;
  endtask

  task automatic rearm();
    send(1'b0);
    pulse_clr();
  endtask

  task automatic t_reset();
    check(det_flag, 1'b0, "R1 flag");
    check(det_irq, 1'b0, "R1 irq");
    check(frm_ready, 1'b1, "R2 ready");
  endtask

  task automatic t_basic();
    rearm();
    cfg_threshold = 6'd3;
    send(1'b1); send(1'b1);
    check(det_flag, 1'b0, "R3 before Nth");
    send(1'b1);
    check(det_flag, 1'b1, "R3 on Nth");
    check(frm_ready, 1'b1, "R2 ready");
    repeat (3) @(negedge clk);
    check(det_flag, 1'b1, "R8 sticky");
    pulse_clr();
    check(det_flag, 1'b0, "R8 clear");
  endtask

  task automatic t_restart();
    rearm();
    cfg_threshold = 6'd4;
    repeat (3) send(1'b1);
    send(1'b0);
    repeat (3) send(1'b1);
    check(det_flag, 1'b0, "R4 restart");
    send(1'b1);
    check(det_flag, 1'b1, "R4 full run");
  endtask

  task automatic t_no_retrigger();
    rearm();
    cfg_threshold = 6'd2;
    send(1'b1); send(1'b1);
    check(det_flag, 1'b1, "R5 first match");
    pulse_clr();
    repeat (5) send(1'b1);
    check(det_flag, 1'b0, "R5 no refire");
    send(1'b0);
    send(1'b1); send(1'b1);
    check(det_flag, 1'b1, "R5 rearmed");
  endtask

  task automatic t_thr_zero();
    rearm();
    cfg_threshold = 6'd0;
    repeat (70) send(1'b1);
    check(det_flag, 1'b0, "R6 disabled");
  endtask

  task automatic t_rx_off();
    rearm();
    cfg_threshold = 6'd3;
    send(1'b1); send(1'b1);
    rx_mode = 1'b0;
    send(1'b0);
    send(1'b1);
    check(det_flag, 1'b0, "R7 ignored while off");
    rx_mode = 1'b1;
    send(1'b1);
    check(det_flag, 1'b1, "R7 run kept");
  endtask

  task automatic t_irq();
    rearm();
    cfg_threshold = 6'd1;
    irq_en = 1'b0;
    send(1'b1);
    check(det_irq, 1'b0, "R9 irq masked");
    irq_en = 1'b1;
    @(negedge clk);
    check(det_irq, 1'b1, "R9 irq on");
    pulse_clr();
    check(det_irq, 1'b0, "R9 irq after clear");
    irq_en = 1'b0;
  endtask

  task automatic t_set_wins();
    rearm();
    cfg_threshold = 6'd2;
    send(1'b1);
    send(1'b1, 1'b1);
    check(det_flag, 1'b1, "R10 set beats clear");
  endtask

  task automatic t_valid_low();
    rearm();
    cfg_threshold = 6'd2;
    send(1'b1);
    frm_silent = 1'b1;
    repeat (4) @(negedge clk);
    check(det_flag, 1'b0, "R11 idle silent");
    send(1'b0);
    frm_silent = 1'b1;
    repeat (2) @(negedge clk);
    send(1'b1);
    check(det_flag, 1'b0, "R11 restart held");
    send(1'b1);
    check(det_flag, 1'b1, "R11 match");
  endtask

  task automatic t_max();
    rearm();
    cfg_threshold = 6'd63;
    repeat (62) send(1'b1);
    check(det_flag, 1'b0, "R12 at 62");
    send(1'b1);
    check(det_flag, 1'b1, "R12 at 63");
    pulse_clr();
    repeat (80) send(1'b1);
    check(det_flag, 1'b0, "R12 no wrap");
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_restart();
    t_no_retrigger();
    t_thr_zero();
    t_rx_off();
    t_irq();
    t_set_wins();
    t_valid_low();
    t_max();
    finish_run();
  end
endmodule